// File: doc/BRIEF.md
# LIN Node Power-Mode Controller

This block is the digital control core of a LIN physical-layer node. It decides which of four operating modes the node is in (unpowered, sleep, standby, normal). Its inputs are a supply-good flag, the enable pin, the local wake pin and the sampled bus level. From the mode it drives the transmitter enable, the receive output and its release, the termination choice and the switch for the external regulator. The analog driver, the receiver thresholds and the thermal sensing are outside the block. They present the bus level as a synchronous digital bit (1 = recessive, 0 = dominant).

Wake-up events in sleep are qualified by two debounce counters, with filter lengths given in clock cycles. A local wake needs the wake pin held low for more than its filter length. A remote wake needs the bus to have been recessive in sleep first, then dominant for at least its filter length, and then back to recessive. After either wake, the node sits in standby and pulls the receive output low as a wake flag until the host raises enable.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While rst_ni is low, or while supply_ok_i is low, mode_o reads 2'b00 (unpowered) and all of the following are 0: tx_en_o, drv_dom_o, rxd_oe_o, inh_o, term_strong_o and term_weak_o.
- R2: From any mode, a low supply_ok_i puts mode_o at 2'b00 on the next clock edge.
- R3: When the supply comes up, the mode becomes sleep (2'b01) if the synchronized enable is low, and normal (2'b11) if it is high.
- R4: In sleep, tx_en_o, rxd_oe_o, inh_o and term_strong_o are 0, and term_weak_o is 1.
- R5: In sleep, a run of more than LOCAL_FILT consecutive low samples on the synchronized wake pin moves the mode to standby (2'b10). Shorter runs leave the mode in sleep.
- R6: In sleep, a dominant run of at least BUS_FILT samples followed by a recessive sample moves the mode to standby. A shorter run does nothing, and so does a dominant level that never returns to recessive.
- R7: A dominant level already present when sleep is entered cannot wake the node. Counting starts only after a recessive sample has been seen in sleep.
- R8: In standby, rxd_oe_o=1, rxd_o=0, inh_o=1, term_strong_o=1, term_weak_o=0 and tx_en_o=0.
- R9: A high synchronized enable in sleep or standby moves the mode to normal.
- R10: In normal, tx_en_o=1, drv_dom_o equals the inverse of txd_i in the same cycle, and rxd_o follows bus_i two clock edges later. inh_o and term_strong_o are 1.
- R11: A low synchronized enable in normal (with supply good) moves the mode to sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| supply_ok_i | input | 1 | Supply above undervoltage threshold |
| en_i | input | 1 | Enable pin, asynchronous |
| wake_ni | input | 1 | Local wake pin, active low, asynchronous |
| bus_i | input | 1 | Sampled bus level, 1 = recessive |
| txd_i | input | 1 | Transmit data from the protocol controller, 0 = dominant |
| tx_en_o | output | 1 | Transmitter enabled |
| drv_dom_o | output | 1 | Driver pulls the bus dominant |
| rxd_o | output | 1 | Receive data or wake flag |
| rxd_oe_o | output | 1 | Receive output driven (0 = floating) |
| inh_o | output | 1 | Regulator inhibit switch on (0 = high impedance) |
| term_strong_o | output | 1 | Slave-class termination selected |
| term_weak_o | output | 1 | Weak pull-up termination selected |
| mode_o | output | 2 | 00 unpowered, 01 sleep, 10 standby, 11 normal |

## Verification
The wake pin and the bus are each swept with low pulses from one cycle up to two cycles past their filter length. This locates the exact width at which each filter accepts a pulse, and it shows the strict versus inclusive bound between the local and the remote path. Two further bus patterns test the release rule and the arming rule: a dominant level held without release, and a dominant level carried over from normal mode into sleep. Supply drops from each mode, power-up with either enable level, and transmit and receive toggling in normal mode cover the remaining transitions and output decodes.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_SLEEP = 2'b01,
    MODE_STBY  = 2'b10,
    MODE_NORM  = 2'b11
  } lin_mode_e;
endpackage

// File: rtl/lin_sync.sv
module lin_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/lin_wake_filter.sv
module lin_wake_filter #(
  parameter int THRESH       = 4,
  parameter bit NEED_RELEASE = 1'b0,
  parameter bit NEED_ARM     = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic active_i,
  output logic wake_o
);
  localparam int CW = $clog2(THRESH + 1);

  logic [CW-1:0] cnt_q;
  logic          hit;
  logic          armed;

  assign hit = (cnt_q == CW'(THRESH));

  if (NEED_ARM) begin : g_arm
    logic armed_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        armed_q <= 1'b0;
      else if (!en_i)     armed_q <= 1'b0;
      else if (!active_i) armed_q <= 1'b1;
    end
    assign armed = armed_q;
  end else begin : g_noarm
    assign armed = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!en_i || !active_i)  cnt_q <= '0;
    else if (armed && !hit)       cnt_q <= cnt_q + 1'b1;
  end

  if (NEED_RELEASE) begin : g_rel
    assign wake_o = en_i & hit & ~active_i;
  end else begin : g_lvl
    assign wake_o = en_i & hit & active_i;
  end

  // R5, R6
  wake_after_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(active_i));
endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
  import lin_mode_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      supply_ok_i,
  input  logic      en_i,
  input  logic      wake_i,
  output lin_mode_e mode_o
);
  lin_mode_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!supply_ok_i) state_d = MODE_OFF;
    else begin
      unique case (state_q)
        MODE_OFF:   state_d = en_i ? MODE_NORM : MODE_SLEEP;
        MODE_SLEEP: if (en_i) state_d = MODE_NORM;
                    else if (wake_i) state_d = MODE_STBY;
        MODE_STBY:  if (en_i) state_d = MODE_NORM;
        MODE_NORM:  if (!en_i) state_d = MODE_SLEEP;
        default:    state_d = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= MODE_OFF;
    else         state_q <= state_d;
  end

  assign mode_o = state_q;

  // R2
  drop_to_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> state_q == MODE_OFF);
  // R9
  stby_to_norm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_STBY && en_i && supply_ok_i) |=> state_q == MODE_NORM);
  // R11
  norm_to_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_NORM && !en_i && supply_ok_i) |=> state_q == MODE_SLEEP);
  // R5
  no_spurious_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_SLEEP && !wake_i && !en_i) |=> state_q != MODE_STBY);
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int LOCAL_FILT = 2000,
  parameter int BUS_FILT   = 2000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       en_i,
  input  logic       wake_ni,
  input  logic       bus_i,
  input  logic       txd_i,
  output logic       tx_en_o,
  output logic       drv_dom_o,
  output logic       rxd_o,
  output logic       rxd_oe_o,
  output logic       inh_o,
  output logic       term_strong_o,
  output logic       term_weak_o,
  output logic [1:0] mode_o
);
  logic [2:0] sync_q;
  logic       en_s, wake_n_s, bus_s;
  logic       loc_wake, bus_wake, in_sleep;
  lin_mode_e  mode;

  lin_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({en_i, wake_ni, bus_i}),
    .q_o   (sync_q)
  );
  assign {en_s, wake_n_s, bus_s} = sync_q;

  assign in_sleep = (mode == MODE_SLEEP);

  lin_wake_filter #(.THRESH(LOCAL_FILT), .NEED_RELEASE(1'b0), .NEED_ARM(1'b0)) u_loc_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (in_sleep),
    .active_i(~wake_n_s),
    .wake_o  (loc_wake)
  );

  lin_wake_filter #(.THRESH(BUS_FILT), .NEED_RELEASE(1'b1), .NEED_ARM(1'b1)) u_bus_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (in_sleep),
    .active_i(~bus_s),
    .wake_o  (bus_wake)
  );

  lin_mode_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .supply_ok_i(supply_ok_i),
    .en_i       (en_s),
    .wake_i     (loc_wake | bus_wake),
    .mode_o     (mode)
  );

  logic awake;
  assign awake         = (mode == MODE_STBY) || (mode == MODE_NORM);
  assign tx_en_o       = (mode == MODE_NORM);
  assign drv_dom_o     = tx_en_o & ~txd_i;
  assign rxd_oe_o      = awake;
  assign rxd_o         = (mode == MODE_NORM) ? bus_s : 1'b0;
  assign inh_o         = awake;
  assign term_strong_o = awake;
  assign term_weak_o   = in_sleep;
  assign mode_o        = mode;

  // R4, R8
  term_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(term_strong_o && term_weak_o));
  // R6
  bus_wake_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wake |-> bus_s);
endmodule

// File: tb/lin_mode_ctrl_bench.sv
module lin_mode_ctrl_bench;
  localparam int LF = 4;
  localparam int BF = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic supply_ok = 1'b0, en = 1'b0, wake_n = 1'b1, bus = 1'b1, txd = 1'b1;
  logic tx_en, drv_dom, rxd, rxd_oe, inh, t_strong, t_weak;
  logic [1:0] mode;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lin_mode_ctrl #(.LOCAL_FILT(LF), .BUS_FILT(BF)) u_lin_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .en_i(en),
    .wake_ni(wake_n), .bus_i(bus), .txd_i(txd),
    .tx_en_o(tx_en), .drv_dom_o(drv_dom), .rxd_o(rxd), .rxd_oe_o(rxd_oe),
    .inh_o(inh), .term_strong_o(t_strong), .term_weak_o(t_weak), .mode_o(mode)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // outputs packed {tx_en, rxd_oe, rxd, inh, strong, weak}
  function automatic int outs();
    return {tx_en, rxd_oe, rxd, inh, t_strong, t_weak};
  endfunction

  task automatic back_to_sleep();
    en = 1'b1; step(5);
    chk("R9 wake to normal", mode, 3);
    en = 1'b0; step(5);
    chk("R11 normal to sleep", mode, 1);
  endtask

  initial begin
    step(3);
    chk("R1 mode in reset", mode, 0);
    chk("R1 outputs in reset", outs(), 0);
    rst_ni = 1'b1; step(3);
    chk("R1 mode without supply", mode, 0);
    chk("R1 outputs without supply", outs(), 0);
    chk("R1 driver without supply", drv_dom, 0);
    supply_ok = 1'b1; step(5);
    chk("R3 power up enable low", mode, 1);
    chk("R4 sleep outputs", outs(), 6'b000001);

    for (int w = 1; w <= LF + 2; w++) begin
      wake_n = 1'b0; step(w);
      wake_n = 1'b1; step(8);
      chk($sformatf("R5 local pulse %0d", w), mode, (w > LF) ? 2 : 1);
      if (w > LF) begin
        chk("R8 standby outputs", outs(), 6'b010110);
        back_to_sleep();
      end
    end

    for (int w = 1; w <= BF + 2; w++) begin
      bus = 1'b0; step(w);
      bus = 1'b1; step(8);
      chk($sformatf("R6 bus pulse %0d", w), mode, (w >= BF) ? 2 : 1);
      if (w >= BF) back_to_sleep();
    end

    bus = 1'b0; step(3 * BF);
    chk("R6 dominant without release", mode, 1);
    bus = 1'b1; step(8);
    chk("R6 release after long dominant", mode, 2);
    back_to_sleep();

    en = 1'b1; step(5);
    bus = 1'b0; en = 1'b0; step(5);
    chk("R11 sleep with bus dominant", mode, 1);
    step(3 * BF);
    bus = 1'b1; step(8);
    chk("R7 carried dominant ignored", mode, 1);
    bus = 1'b0; step(BF);
    bus = 1'b1; step(8);
    chk("R7 armed after recessive", mode, 2);

    en = 1'b1; step(5);
    chk("R9 standby to normal", mode, 3);
    chk("R10 normal outputs", {tx_en, rxd_oe, inh, t_strong, t_weak}, 5'b11110);
    txd = 1'b0; #1;
    chk("R10 driver dominant", drv_dom, 1);
    txd = 1'b1; #1;
    chk("R10 driver recessive", drv_dom, 0);
    bus = 1'b0; step(1);
    chk("R10 rxd before latency", rxd, 1);
    step(1);
    chk("R10 rxd after latency", rxd, 0);
    bus = 1'b1; step(2);
    chk("R10 rxd recessive", rxd, 1);

    supply_ok = 1'b0; step(1);
    chk("R2 drop from normal", mode, 0);
    chk("R1 outputs after drop", outs(), 0);
    step(2);
    supply_ok = 1'b1; step(3);
    chk("R3 power up enable high", mode, 3);
    en = 1'b0; step(5);
    chk("R11 normal to sleep", mode, 1);
    supply_ok = 1'b0; step(1);
    chk("R2 drop from sleep", mode, 0);
    supply_ok = 1'b1; step(2);
    wake_n = 1'b0; step(LF + 1);
    wake_n = 1'b1; step(4);
    chk("R5 wake before drop", mode, 2);
    supply_ok = 1'b0; step(1);
    chk("R2 drop from standby", mode, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule